// File: doc/BRIEF.md
# Expansion Bus Cycle Controller with Dynamic Sizing

This block is the master side of a 16/8-bit PC/AT-style expansion bus. A local agent hands it one memory or I/O transfer at a time, either a byte or a 16-bit word. The controller runs the matching bus cycle or cycles and returns one response per request. The request side is a valid/ready stream. A request is taken only while `req_ready` is high, and `req_ready` stays low from acceptance until the response has been consumed. The response side is also a stream. `rsp_valid` and its payload hold steady while `rsp_ready` is low, so a slow consumer stalls the controller without losing data.

Each bus cycle has three parts: an address phase of `ADDR_CLKS` clocks, a command phase, and one recovery clock. At the end of the address phase the controller samples the target's 16-bit width sense. A word request to a target that reports only 8 bits is carried out as two byte cycles on the low data lane, and the read bytes are joined into one word. A target can stretch the command with its ready line or cut it short with the zero-wait line. A stretch that lasts too long is broken off and reported as an error.

Top module: `xbus_cycle_ctrl`

## Requirements
- R1: `req_ready` is high only while the controller is idle with no response pending. A request is accepted on a clock where `req_valid` and `req_ready` are both high. `rsp_valid`, `rsp_rdata` and `rsp_err` hold until `rsp_ready` is high, and no new bus cycle starts before then.
- R2: During the command phase exactly one active-low strobe is driven low: `bus_memr_n` for a memory read, `bus_memw_n` for a memory write, `bus_ior_n` for an I/O read, `bus_iow_n` for an I/O write. All four are high at every other time.
- R3: A word request (`req_wide`=1) to a target that drives `bus_is16_n` low at the end of the address phase runs one cycle. That cycle uses the even address (bit 0 cleared) with `bus_sbhe_n` low during the command. The write word goes on `bus_dout[15:0]`, and the read word is taken from `bus_din[15:0]`.
- R4: A word request to a target with `bus_is16_n` high runs two byte cycles. The first uses the even address and the second uses the even address plus 1. Both have `bus_sbhe_n` high in the command phase and use lane [7:0]. Writes send the low byte first. Reads place the first byte in `rsp_rdata[7:0]` and the second byte in `rsp_rdata[15:8]`.
- R5: A byte request (`req_wide`=0) runs one cycle at the given address, with `bus_sbhe_n` high and data on lane [7:0]. `rsp_rdata[15:8]` reads zero, and `bus_din[15:8]` is ignored.
- R6: With `bus_rdy` high and `bus_zws_n` high, the command lasts exactly `CMD_CLKS` clocks. The level of `bus_rdy` before the last default clock has no effect.
- R7: If `bus_rdy` is low on the last default command clock, the command is extended one clock at a time. It ends on the first clock where `bus_rdy` is seen high.
- R8: `bus_zws_n` low ends the command on any command clock from the second one onward. On the first command clock it is ignored.
- R9: If the command has been stretched by `TIMEOUT_CLKS` clocks (clock rate in MHz times the limit in µs) and `bus_rdy` is still low, the command ends with `rsp_err`=1. A timed-out read returns 16'hFFFF. The second byte cycle of a split word is then skipped.
- R10: `bus_addr` and `bus_sbhe_n` are stable throughout each command. `bus_doe` is high only for writes, from the address phase through recovery, and never while a read strobe is low.
- R11: Between the two byte cycles of a split word, every strobe stays high for one recovery clock plus `ADDR_CLKS` address clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O space, 0 = memory space |
| req_wide | input | 1 | 1 = 16-bit transfer, 0 = byte |
| req_addr | input | ADDR_W | Transfer address |
| req_wdata | input | 16 | Write data (byte requests use [7:0]) |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_rdata | output | 16 | Read data |
| rsp_err | output | 1 | Transfer ended by timeout |
| bus_addr | output | ADDR_W | Bus address |
| bus_sbhe_n | output | 1 | High byte enable, active low |
| bus_memr_n | output | 1 | Memory read strobe, active low |
| bus_memw_n | output | 1 | Memory write strobe, active low |
| bus_ior_n | output | 1 | I/O read strobe, active low |
| bus_iow_n | output | 1 | I/O write strobe, active low |
| bus_dout | output | 16 | Write data to the bus |
| bus_doe | output | 1 | Write data drive enable |
| bus_din | input | 16 | Read data from the bus |
| bus_is16_n | input | 1 | Target is 16 bits wide, active low |
| bus_rdy | input | 1 | Target ready; low stretches the command |
| bus_zws_n | input | 1 | Zero-wait request, active low |

## Verification
The bench builds the controller with a 16-bit address, a 4-clock default command, a 2-clock address phase and a 1 µs limit at 50 MHz, so the timeout falls after 50 stretched clocks. With these values the bench reaches a timeout on a word cycle, on the first half of a split word and on a write. It also reaches a stretch that ends on exactly the last clock before the limit, alongside zero-wait on the first and second command clocks. The short address phase makes the gap between split byte cycles measurable as three clocks.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

  // Sequencer phases of one request.
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_CMD,
    ST_RECOV,
    ST_RESP
  } xb_state_e;

  // Why a command phase ends on the current clock.
  typedef enum logic [1:0] {
    END_NONE,
    END_READY,
    END_ZWS,
    END_TIMEOUT
  } xb_end_e;

  // Captured kind of transfer.
  typedef struct packed {
    logic write;
    logic io;
    logic wide;
  } xb_op_t;

endpackage

// File: rtl/xbus_timer.sv
module xbus_timer
  import xbus_pkg::*;
#(
  parameter int unsigned CMD_CLKS     = 6,
  parameter int unsigned ADDR_CLKS    = 1,
  parameter int unsigned TIMEOUT_CLKS = 800
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    addr_phase,
  input  logic    cmd_phase,
  input  logic    bus_rdy,
  input  logic    bus_zws_n,
  output logic    addr_done,
  output xb_end_e cmd_end
);

  localparam int unsigned ACW = $clog2(ADDR_CLKS + 1);
  localparam int unsigned CCW = $clog2(CMD_CLKS + 2);
  localparam int unsigned TW  = $clog2(TIMEOUT_CLKS + 1);

  logic [ACW-1:0] acnt;   // clocks spent in the address phase
  logic [CCW-1:0] ccnt;   // 1-based index of the current command clock
  logic [TW-1:0]  scnt;   // clocks stretched past the default length
  logic           at_default;
  logic           past_first;

  assign at_default = (ccnt == CCW'(CMD_CLKS));
  assign past_first = (ccnt >= CCW'(2));
  assign addr_done  = addr_phase && (acnt == ACW'(ADDR_CLKS - 1));

  // Ready on the default clock wins, then zero-wait, then the limit.
  always_comb begin
    cmd_end = END_NONE;
    if (cmd_phase) begin
      if (at_default && bus_rdy)
        cmd_end = END_READY;
      else if (past_first && !bus_zws_n)
        cmd_end = END_ZWS;
      else if (at_default && (scnt == TW'(TIMEOUT_CLKS)))
        cmd_end = END_TIMEOUT;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acnt <= '0;
      ccnt <= CCW'(1);
      scnt <= '0;
    end else begin
      acnt <= addr_phase ? acnt + ACW'(1) : '0;
      if (!cmd_phase) begin
        ccnt <= CCW'(1);
        scnt <= '0;
      end else if (cmd_end == END_NONE) begin
        if (!at_default)
          ccnt <= ccnt + CCW'(1);
        else
          scnt <= scnt + TW'(1);
      end
    end
  end

  AST_STRETCH_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_phase |-> scnt <= TW'(TIMEOUT_CLKS)); // R9

  AST_NO_STRETCH_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_phase && !at_default) |-> scnt == '0); // R7

endmodule

// File: rtl/xbus_lane.sv
module xbus_lane #(
  parameter int unsigned ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [15:0]       req_wdata,
  input  logic              wide,
  input  logic              full16,
  input  logic              hi_byte,
  input  logic              addr_phase,
  input  logic              capture,
  input  logic              timeout,
  input  logic [15:0]       bus_din,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_sbhe_n,
  output logic [15:0]       bus_dout,
  output logic [15:0]       rdata
);

  logic [ADDR_W-1:0] addr_q;
  logic [15:0]       wdata_q;
  logic              odd_part;

  // The second part of a split word always sits at the odd byte.
  assign odd_part = hi_byte && !full16;

  always_comb begin
    if (wide)
      bus_addr = {addr_q[ADDR_W-1:1], odd_part};
    else
      bus_addr = addr_q;
  end

  // The high byte is enabled while a word might still go out in one
  // cycle (address phase of the first part) and for a true 16-bit cycle.
  assign bus_sbhe_n = !(wide && !hi_byte && (full16 || addr_phase));

  always_comb begin
    if (full16)
      bus_dout = wdata_q;
    else if (odd_part)
      bus_dout = {8'h00, wdata_q[15:8]};
    else
      bus_dout = {8'h00, wdata_q[7:0]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      rdata   <= '0;
    end else if (load) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      rdata   <= '0;
    end else if (capture) begin
      if (timeout)
        rdata <= '1;
      else if (full16)
        rdata <= bus_din;
      else if (odd_part)
        rdata[15:8] <= bus_din[7:0];
      else
        rdata[7:0] <= bus_din[7:0];
    end
  end

  AST_HIGH_PART_ODD: assert property (@(posedge clk) disable iff (!rst_n)
    (wide && hi_byte) |-> (bus_addr[0] && bus_sbhe_n)); // R4

endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
  import xbus_pkg::*;
#(
  parameter int unsigned CMD_CLKS = 6
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    req_valid,
  input  logic    req_write,
  input  logic    req_io,
  input  logic    req_wide,
  input  logic    rsp_ready,
  input  logic    bus_is16_n,
  input  logic    addr_done,
  input  xb_end_e cmd_end,
  output logic    req_ready,
  output logic    rsp_valid,
  output logic    rsp_err,
  output xb_op_t  op_q,
  output logic    full16,
  output logic    hi_byte,
  output logic    load,
  output logic    capture,
  output logic    timeout_hit,
  output logic    addr_phase,
  output logic    cmd_phase,
  output logic    bus_memr_n,
  output logic    bus_memw_n,
  output logic    bus_ior_n,
  output logic    bus_iow_n,
  output logic    bus_doe
);

  xb_state_e state, state_d;
  logic      err_q;
  logic      more;

  assign more = op_q.wide && !full16 && !hi_byte && !err_q;

  always_comb begin
    state_d = state;
    unique case (state)
      ST_IDLE:  if (req_valid)             state_d = ST_ADDR;
      ST_ADDR:  if (addr_done)             state_d = ST_CMD;
      ST_CMD:   if (cmd_end != END_NONE)   state_d = ST_RECOV;
      ST_RECOV: state_d = more ? ST_ADDR : ST_RESP;
      ST_RESP:  if (rsp_ready)             state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  assign req_ready   = (state == ST_IDLE);
  assign rsp_valid   = (state == ST_RESP);
  assign rsp_err     = err_q;
  assign addr_phase  = (state == ST_ADDR);
  assign cmd_phase   = (state == ST_CMD);
  assign load        = req_ready && req_valid;
  assign timeout_hit = (cmd_end == END_TIMEOUT);
  assign capture     = cmd_phase && (cmd_end != END_NONE) && !op_q.write;

  assign bus_memr_n = !(cmd_phase && !op_q.io && !op_q.write);
  assign bus_memw_n = !(cmd_phase && !op_q.io &&  op_q.write);
  assign bus_ior_n  = !(cmd_phase &&  op_q.io && !op_q.write);
  assign bus_iow_n  = !(cmd_phase &&  op_q.io &&  op_q.write);
  assign bus_doe    = op_q.write &&
                      (state == ST_ADDR || state == ST_CMD || state == ST_RECOV);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      op_q    <= '0;
      full16  <= 1'b0;
      hi_byte <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state <= state_d;
      if (load) begin
        op_q    <= '{write: req_write, io: req_io, wide: req_wide};
        full16  <= 1'b0;
        hi_byte <= 1'b0;
        err_q   <= 1'b0;
      end
      if (addr_done && !hi_byte)
        full16 <= op_q.wide && !bus_is16_n;
      if (timeout_hit)
        err_q <= 1'b1;
      if (state == ST_RECOV && more)
        hi_byte <= 1'b1;
    end
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({~bus_memr_n, ~bus_memw_n, ~bus_ior_n, ~bus_iow_n})); // R2

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_err))); // R1

  AST_RECOVERY_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_phase && $past(cmd_phase)) |=> !cmd_phase); // R11

  AST_NO_FIRST_CLK_END: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_phase && $past(state) != ST_CMD && CMD_CLKS > 1) |=> cmd_phase); // R8

endmodule

// File: rtl/xbus_cycle_ctrl.sv
module xbus_cycle_ctrl
  import xbus_pkg::*;
#(
  parameter int unsigned ADDR_W       = 20,
  parameter int unsigned CMD_CLKS     = 6,
  parameter int unsigned ADDR_CLKS    = 1,
  parameter int unsigned CLK_MHZ      = 50,
  parameter int unsigned TIMEOUT_US   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_io,
  input  logic              req_wide,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [15:0]       req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [15:0]       rsp_rdata,
  output logic              rsp_err,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_sbhe_n,
  output logic              bus_memr_n,
  output logic              bus_memw_n,
  output logic              bus_ior_n,
  output logic              bus_iow_n,
  output logic [15:0]       bus_dout,
  output logic              bus_doe,
  input  logic [15:0]       bus_din,
  input  logic              bus_is16_n,
  input  logic              bus_rdy,
  input  logic              bus_zws_n
);

  localparam int unsigned TIMEOUT_CLKS = CLK_MHZ * TIMEOUT_US;

  xb_end_e cmd_end;
  xb_op_t  op_q;
  logic    addr_done, addr_phase, cmd_phase;
  logic    full16, hi_byte, load, capture, timeout_hit;

  xbus_timer #(
    .CMD_CLKS    (CMD_CLKS),
    .ADDR_CLKS   (ADDR_CLKS),
    .TIMEOUT_CLKS(TIMEOUT_CLKS)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr_phase(addr_phase),
    .cmd_phase (cmd_phase),
    .bus_rdy   (bus_rdy),
    .bus_zws_n (bus_zws_n),
    .addr_done (addr_done),
    .cmd_end   (cmd_end)
  );

  xbus_seq #(
    .CMD_CLKS(CMD_CLKS)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_io     (req_io),
    .req_wide   (req_wide),
    .rsp_ready  (rsp_ready),
    .bus_is16_n (bus_is16_n),
    .addr_done  (addr_done),
    .cmd_end    (cmd_end),
    .req_ready  (req_ready),
    .rsp_valid  (rsp_valid),
    .rsp_err    (rsp_err),
    .op_q       (op_q),
    .full16     (full16),
    .hi_byte    (hi_byte),
    .load       (load),
    .capture    (capture),
    .timeout_hit(timeout_hit),
    .addr_phase (addr_phase),
    .cmd_phase  (cmd_phase),
    .bus_memr_n (bus_memr_n),
    .bus_memw_n (bus_memw_n),
    .bus_ior_n  (bus_ior_n),
    .bus_iow_n  (bus_iow_n),
    .bus_doe    (bus_doe)
  );

  xbus_lane #(
    .ADDR_W(ADDR_W)
  ) u_lane (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .wide      (op_q.wide),
    .full16    (full16),
    .hi_byte   (hi_byte),
    .addr_phase(addr_phase),
    .capture   (capture),
    .timeout   (timeout_hit),
    .bus_din   (bus_din),
    .bus_addr  (bus_addr),
    .bus_sbhe_n(bus_sbhe_n),
    .bus_dout  (bus_dout),
    .rdata     (rsp_rdata)
  );

  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_phase && $past(cmd_phase)) |-> ($stable(bus_addr) && $stable(bus_sbhe_n))); // R10

  AST_TIMEOUT_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err && !op_q.write) |-> rsp_rdata == 16'hFFFF); // R9

  AST_DOE_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    bus_doe |-> (bus_memr_n && bus_ior_n)); // R10

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!rsp_valid && !bus_doe && bus_memr_n && bus_memw_n)); // R1

endmodule

// File: tb/test_xbus_cycle_ctrl.sv
module test_xbus_cycle_ctrl;

  localparam int ADDR_W = 16;
  localparam int CMD    = 4;
  localparam int ACLK   = 2;
  localparam int TO     = 50;   // 50 MHz x 1 us

  typedef struct packed {
    logic        wr;
    logic        io;
    logic        wide;
    logic        t16;
    logic        hang;
    logic [3:0]  zws;
    logic [7:0]  str;
    logic [15:0] addr;
    logic [15:0] wdata;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b0,1'b0,1'b0,1'b0,4'd0,8'd0, 16'h1234,16'h0000}, // R5 mem rd byte
    '{1'b1,1'b0,1'b0,1'b0,1'b0,4'd0,8'd0, 16'h0451,16'h00C3}, // R5 mem wr byte
    '{1'b0,1'b1,1'b1,1'b1,1'b0,4'd0,8'd0, 16'h0300,16'h0000}, // R3 io rd word
    '{1'b1,1'b1,1'b1,1'b1,1'b0,4'd0,8'd0, 16'h0302,16'hBEEF}, // R3 io wr word
    '{1'b0,1'b0,1'b1,1'b0,1'b0,4'd0,8'd0, 16'h2000,16'h0000}, // R4 split rd
    '{1'b1,1'b0,1'b1,1'b0,1'b0,4'd0,8'd0, 16'h2006,16'h1357}, // R4 split wr
    '{1'b0,1'b0,1'b0,1'b0,1'b0,4'd0,8'd5, 16'h0777,16'h0000}, // R7 stretch
    '{1'b0,1'b1,1'b0,1'b0,1'b0,4'd2,8'd0, 16'h0081,16'h0000}, // R8 zws clk 2
    '{1'b0,1'b0,1'b0,1'b0,1'b0,4'd1,8'd0, 16'h0F0F,16'h0000}, // R8 zws clk 1
    '{1'b0,1'b0,1'b1,1'b1,1'b1,4'd0,8'd0, 16'h4444,16'h0000}, // R9 timeout word
    '{1'b0,1'b0,1'b1,1'b0,1'b1,4'd0,8'd0, 16'h5550,16'h0000}, // R9 timeout split
    '{1'b1,1'b1,1'b0,1'b0,1'b1,4'd0,8'd0, 16'h0060,16'h00AA}, // R9 timeout wr
    '{1'b0,1'b0,1'b1,1'b0,1'b0,4'd0,8'd0, 16'h2001,16'h0000}, // R4 odd addr
    '{1'b0,1'b0,1'b0,1'b1,1'b0,4'd0,8'd50,16'h0123,16'h0000}  // R7 edge of limit
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0, req_write = 1'b0, req_io = 1'b0, req_wide = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [15:0]       req_wdata = '0;
  logic              rsp_ready = 1'b1;
  logic              req_ready, rsp_valid, rsp_err;
  logic [15:0]       rsp_rdata;
  logic [ADDR_W-1:0] bus_addr;
  logic              bus_sbhe_n, bus_memr_n, bus_memw_n, bus_ior_n, bus_iow_n, bus_doe;
  logic [15:0]       bus_dout;
  logic [15:0]       bus_din = 16'hDEAD;
  logic              bus_is16_n = 1'b1, bus_rdy = 1'b1, bus_zws_n = 1'b1;

  always #10 clk = ~clk;

  xbus_cycle_ctrl #(
    .ADDR_W(ADDR_W), .CMD_CLKS(CMD), .ADDR_CLKS(ACLK), .CLK_MHZ(50), .TIMEOUT_US(1)
  ) i_xbus_cycle_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_io(req_io), .req_wide(req_wide), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .bus_addr(bus_addr), .bus_sbhe_n(bus_sbhe_n),
    .bus_memr_n(bus_memr_n), .bus_memw_n(bus_memw_n),
    .bus_ior_n(bus_ior_n), .bus_iow_n(bus_iow_n),
    .bus_dout(bus_dout), .bus_doe(bus_doe), .bus_din(bus_din),
    .bus_is16_n(bus_is16_n), .bus_rdy(bus_rdy), .bus_zws_n(bus_zws_n)
  );

  int checks = 0;
  int errors = 0;
  bit wd_hit = 1'b0;
  int cyc = 0;

  task automatic chk(input string req, input string what, input logic [31:0] got,
                     input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  function automatic logic [7:0] tgt_byte(input logic [15:0] a);
    return a[7:0] ^ 8'hA5 ^ a[15:8];
  endfunction

  // ---------------- target model ----------------
  int          cur_str = 0;
  int          cur_zws = 0;
  bit          cur_hang = 1'b0;
  int          k = 0;
  int          nc = 0;
  int          idle = 0;
  logic [15:0] lg_addr [16];
  logic        lg_sbhe [16];
  logic [3:0]  lg_stb  [16];
  logic [15:0] lg_dout [16];
  logic        lg_doe  [16];
  int          lg_len  [16];
  int          lg_gap  [16];

  always @(negedge clk) begin
    logic [3:0] stb;
    stb = {bus_memr_n, bus_memw_n, bus_ior_n, bus_iow_n};
    if (rst_n && stb != 4'hF) begin
      if (k == 0) begin
        lg_addr[nc % 16] = bus_addr;
        lg_sbhe[nc % 16] = bus_sbhe_n;
        lg_stb[nc % 16]  = stb;
        lg_gap[nc % 16]  = idle;
      end
      k = k + 1;
      lg_dout[nc % 16] = bus_dout;
      lg_doe[nc % 16]  = bus_doe;
      bus_rdy   = cur_hang ? 1'b0 : (k >= CMD + cur_str);
      bus_zws_n = !(cur_zws != 0 && k >= cur_zws);
      bus_din   = bus_sbhe_n ? {8'hEE, tgt_byte(bus_addr)}
                             : {tgt_byte(bus_addr | 16'h1), tgt_byte(bus_addr)};
    end else begin
      if (k != 0) begin
        lg_len[nc % 16] = k;
        nc   = nc + 1;
        idle = 0;
        k    = 0;
      end
      idle      = idle + 1;
      bus_rdy   = 1'b1;
      bus_zws_n = 1'b1;
      bus_din   = 16'hDEAD;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !wd_hit) begin
      wd_hit = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: got hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // ---------------- vector runner ----------------
  task automatic issue(input vec_t v);
    req_write  = v.wr;
    req_io     = v.io;
    req_wide   = v.wide;
    req_addr   = v.addr;
    req_wdata  = v.wdata;
    bus_is16_n = !v.t16;
    req_valid  = 1'b1;
    while (!req_ready && !wd_hit) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic run_vec(input vec_t v, input int idx);
    int          base;
    int          ncyc;
    int          elen;
    int          zk;
    logic [15:0] ae;
    logic [15:0] erd;
    logic [3:0]  estb;
    logic        split;
    string       tag;
    tag       = $sformatf("vec%0d", idx);
    cur_str   = v.str;
    cur_zws   = v.zws;
    cur_hang  = v.hang;
    base      = nc;
    issue(v);
    while (!rsp_valid && !wd_hit) @(negedge clk);
    ae    = v.addr & 16'hFFFE;
    split = v.wide && !v.t16;
    if (v.wr)        erd = 16'h0000;
    else if (v.hang) erd = 16'hFFFF;
    else if (v.wide) erd = {tgt_byte(ae | 16'h1), tgt_byte(ae)};
    else             erd = {8'h00, tgt_byte(v.addr)};
    chk(v.hang ? "R9" : (split ? "R4" : (v.wide ? "R3" : "R5")),
        {tag, " rdata"}, {16'h0, rsp_rdata}, {16'h0, erd});
    chk("R9", {tag, " err"}, {31'h0, rsp_err}, {31'h0, v.hang});
    @(negedge clk);
    ncyc = (split && !v.hang) ? 2 : 1;
    chk(split ? "R4" : "R3", {tag, " cycles"}, nc - base, ncyc);
    estb = v.io ? (v.wr ? 4'b1110 : 4'b1101) : (v.wr ? 4'b1011 : 4'b0111);
    zk   = (v.zws == 0) ? 1000 : ((v.zws < 2) ? 2 : int'(v.zws));
    if (v.hang)            elen = CMD + TO;
    else if (zk < CMD)     elen = zk;
    else                   elen = CMD + v.str;
    chk("R2", {tag, " strobe"}, {28'h0, lg_stb[base % 16]}, {28'h0, estb});
    chk(v.hang ? "R9" : (v.zws != 0 ? "R8" : (v.str != 0 ? "R7" : "R6")),
        {tag, " length"}, lg_len[base % 16], elen);
    chk(v.wide ? "R3" : "R5", {tag, " addr0"}, {16'h0, lg_addr[base % 16]},
        {16'h0, v.wide ? ae : v.addr});
    chk(v.wide && v.t16 ? "R3" : "R5", {tag, " sbhe0"}, {31'h0, lg_sbhe[base % 16]},
        {31'h0, !(v.wide && v.t16)});
    chk("R10", {tag, " doe"}, {31'h0, lg_doe[base % 16]}, {31'h0, v.wr});
    if (v.wr)
      chk(v.wide ? "R3" : "R5", {tag, " wdata0"},
          {16'h0, (v.wide && v.t16) ? lg_dout[base % 16] : {8'h00, lg_dout[base % 16][7:0]}},
          {16'h0, (v.wide && v.t16) ? v.wdata : {8'h00, v.wdata[7:0]}});
    if (ncyc == 2) begin
      chk("R4", {tag, " addr1"}, {16'h0, lg_addr[(base + 1) % 16]}, {16'h0, ae | 16'h1});
      chk("R4", {tag, " sbhe1"}, {31'h0, lg_sbhe[(base + 1) % 16]}, 32'h1);
      chk("R11", {tag, " gap"}, lg_gap[(base + 1) % 16], 1 + ACLK);
      if (v.wr)
        chk("R4", {tag, " wdata1"}, {24'h0, lg_dout[(base + 1) % 16][7:0]},
            {24'h0, v.wdata[15:8]});
    end
  endtask

  initial begin
    vec_t bp;
    int   base;
    repeat (3) @(negedge clk);
    // reset state
    chk("R1", "reset req_ready", {31'h0, req_ready}, 32'h1);
    chk("R1", "reset rsp_valid", {31'h0, rsp_valid}, 32'h0);
    chk("R2", "reset strobes", {28'h0, bus_memr_n, bus_memw_n, bus_ior_n, bus_iow_n}, 32'hF);
    chk("R10", "reset doe", {31'h0, bus_doe}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++)
      if (!wd_hit) run_vec(VECS[i], i);

    // back-pressure: response held, second request waits
    bp        = VECS[0];
    cur_str   = 0;
    cur_zws   = 0;
    cur_hang  = 1'b0;
    rsp_ready = 1'b0;
    issue(bp);
    while (!rsp_valid && !wd_hit) @(negedge clk);
    base      = nc;
    req_valid = 1'b1;
    req_addr  = 16'h0999;
    for (int j = 0; j < 5; j++) begin
      @(negedge clk);
      chk("R1", "held rsp_valid", {31'h0, rsp_valid}, 32'h1);
      chk("R1", "held rdata", {16'h0, rsp_rdata}, {24'h0, tgt_byte(bp.addr)});
      chk("R1", "held req_ready", {31'h0, req_ready}, 32'h0);
    end
    chk("R1", "no cycle while held", nc - base, 0);
    rsp_ready = 1'b1;
    @(negedge clk);
    while (!req_ready && !wd_hit) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid && !wd_hit) @(negedge clk);
    chk("R1", "queued request data", {16'h0, rsp_rdata}, {24'h0, tgt_byte(16'h0999)});
    chk("R5", "queued request addr", {16'h0, lg_addr[base % 16]}, 32'h0999);
    @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule